// File: doc/BRIEF.md
# Multi-revision image selector

This block decides which of up to four stored configuration images a configuration memory delivers, and where that image starts. The memory is divided into fixed 8 Mb blocks. Each image fills a whole number of those blocks, and unused space in an image's last block reads as all ones. A static table gives, for each image, its first block index and its length in blocks. The selector takes the revision code either from two external select pins or from two programmable internal bits. A mode input picks the source at run time.

The revision is latched only at defined moments. These are the release of power-on reset, a deassertion of chip enable, a falling edge of the output-enable/reset input or a rising edge of the reconfiguration strobe (both only while chip enable is asserted), and a configuration request arriving from the test port. Every control input passes through a two-flop synchroniser, and its edges are found on the system clock. After each latch, a single-cycle sample strobe tells the address counter to load the new start block. If the latched image has zero length, it is flagged invalid and no strobe is issued. A latch caused by a test-port request also produces a go pulse. That pulse fires only after the new revision is visible, so the reconfiguration pulse it starts always uses the fresh selection.

The control is a four-state machine. `ST_POR` holds while power-on reset is asserted. `ST_IDLE` waits for a qualified event. `ST_LATCH` captures the selection and its table entry. `ST_ANNOUNCE` issues the strobe and the go pulse. The transitions are:
- POR release: `ST_POR` to `ST_LATCH`.
- Event: `ST_IDLE` to `ST_LATCH`.
- Capture: `ST_LATCH` to `ST_ANNOUNCE`.
- Done: `ST_ANNOUNCE` to `ST_IDLE`.
- Retrigger: `ST_ANNOUNCE` to `ST_LATCH`, taken for an event seen during `ST_LATCH` or `ST_ANNOUNCE`.
- Power loss: `ST_IDLE` or `ST_ANNOUNCE` to `ST_POR`, taken whenever power-on reset is reasserted.

Top module: `rev_select_top`

## Requirements
- R1: `rev_o` carries the latched revision as a 2-bit binary code: image 0 = 00, 1 = 01, 2 = 10, 3 = 11.
- R2: While `use_int_i` is low at the latch, the revision is taken from `sel_pin_i`.
- R3: While `use_int_i` is high at the latch, the revision is taken from `sel_int_i`.
- R4: After `rst_n` is asserted, `rev_o`, `start_blk_o`, `blk_cnt_o`, `rev_valid_o`, `sample_stb_o` and `cfg_go_o` are all zero. No latch happens while `por_i` is high. A latch happens when `por_i` falls.
- R5: A rising edge of `ce_n_i` (chip disabled) causes a latch. A falling edge of `ce_n_i` does not.
- R6: A falling edge of `oe_rst_n_i` or a rising edge of `cfg_n_i` causes a latch only while `ce_n_i` is low. While `ce_n_i` is high, these edges are ignored. Changes on the select inputs alone never cause a latch.
- R7: A rising edge of `cfg_req_i` causes a latch and one single-cycle pulse on `cfg_go_o`. The pulse comes in the same cycle as the sample strobe, and the new `rev_o` is already visible one cycle earlier. Other latch causes give no `cfg_go_o` pulse.
- R8: `start_blk_o` and `blk_cnt_o` equal the table entry of the latched revision. A zero count drives `rev_valid_o` low, and no sample strobe is issued for that latch.
- R9: `sample_stb_o` is high for exactly one cycle per latch of a valid image. The new `rev_o` becomes visible at the 4th rising clock edge after a qualifying input edge, and the strobe is high during the cycle after the 5th edge, counting the first edge that sees the new input level as the 1st.
- R10: The entry for revision i sits at bits [i*BIDX_W +: BIDX_W] of `tbl_start_i` and at bits [i*BLEN_W +: BLEN_W] of `tbl_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset indication, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_rst_n_i | input | 1 | Output enable / reset, active low |
| cfg_n_i | input | 1 | Reconfiguration strobe, active low |
| cfg_req_i | input | 1 | Configuration request from the test port |
| use_int_i | input | 1 | 0: select pins choose, 1: internal bits choose |
| sel_pin_i | input | 2 | External revision select pins |
| sel_int_i | input | 2 | Programmable internal revision bits |
| tbl_start_i | input | 4*BIDX_W | Start block index per revision |
| tbl_len_i | input | 4*BLEN_W | Block count per revision |
| rev_o | output | 2 | Latched revision code |
| start_blk_o | output | BIDX_W | Start block of latched revision |
| blk_cnt_o | output | BLEN_W | Block count of latched revision |
| rev_valid_o | output | 1 | Latched revision has a non-zero length |
| sample_stb_o | output | 1 | One-cycle load strobe for the address counter |
| cfg_go_o | output | 1 | One-cycle go pulse after a test-port-requested latch |

## Verification
The bench sweeps every combination of mode, pin code, internal code and latch cause against a table that contains an empty image. A selector that decodes the mode backwards, or swaps table slots, shows up as a wrong revision or a wrong start block. An empty image that still raises the strobe would let the address counter load a region that holds nothing. An output-enable or strobe edge arriving while the chip is disabled must leave the revision unchanged; a design that ignored the chip-enable qualification would silently switch images. The exact edge on which the revision and the strobe appear is measured, and so is the position of the go pulse. A design whose go pulse led the latch would start reconfiguration from the stale image.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    localparam int NREV  = 4;
    localparam int SEL_W = $clog2(NREV);

    // bit positions inside the synchronised control vector
    localparam int SB_CE   = 0;
    localparam int SB_OE   = 1;
    localparam int SB_CF   = 2;
    localparam int SB_JT   = 3;
    localparam int SB_POR  = 4;
    localparam int SB_MODE = 5;
    localparam int SB_PIN  = 6;
    localparam int SB_INT  = SB_PIN + SEL_W;
    localparam int SB_W    = SB_INT + SEL_W;

    // idle levels: strobes/enables deasserted, power-on reset asserted
    localparam logic [SB_W-1:0] SB_IDLE =
        SB_W'((1 << SB_CE) | (1 << SB_OE) | (1 << SB_CF) | (1 << SB_POR));

    typedef enum logic [1:0] {
        ST_POR      = 2'd0,
        ST_IDLE     = 2'd1,
        ST_LATCH    = 2'd2,
        ST_ANNOUNCE = 2'd3
    } rsel_state_e;

    typedef struct packed {
        logic ce_rise;
        logic oe_fall;
        logic cf_rise;
        logic jt_rise;
    } rsel_trig_t;
endpackage

// File: rtl/rsel_sync.sv
module rsel_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                sync_q <= meta_q;
            end
        end
        assign q_o[b] = sync_q;
    end
endmodule

// File: rtl/rsel_edge.sv
module rsel_edge
    import rsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] sync_i,
    output rsel_trig_t      trig_o,
    output logic            any_o,
    output logic            por_o
);
    localparam int PW = 4;
    localparam logic [PW-1:0] PREV_RST = SB_IDLE[PW-1:0];

    logic [PW-1:0] prev_q;
    logic          ce_n, oe_n, cf_n, jt;

    assign ce_n = sync_i[SB_CE];
    assign oe_n = sync_i[SB_OE];
    assign cf_n = sync_i[SB_CF];
    assign jt   = sync_i[SB_JT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PREV_RST;
        else        prev_q <= sync_i[PW-1:0];
    end

    always_comb begin
        trig_o.ce_rise = ce_n & ~prev_q[SB_CE];
        trig_o.oe_fall = ~oe_n & prev_q[SB_OE] & ~ce_n;
        trig_o.cf_rise = cf_n & ~prev_q[SB_CF] & ~ce_n;
        trig_o.jt_rise = jt & ~prev_q[SB_JT];
    end

    assign any_o = |trig_o;
    assign por_o = sync_i[SB_POR];
endmodule

// File: rtl/rsel_fsm.sv
module rsel_fsm
    import rsel_pkg::*;
#(
    parameter int BIDX_W = 4,
    parameter int BLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  rsel_trig_t        trig_i,
    input  logic              any_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [BIDX_W-1:0] start_i,
    input  logic [BLEN_W-1:0] len_i,
    output logic [SEL_W-1:0]  rev_o,
    output logic [BIDX_W-1:0] start_o,
    output logic [BLEN_W-1:0] cnt_o,
    output logic              valid_o,
    output logic              stb_o,
    output logic              go_o
);
    rsel_state_e state_q, state_d;
    logic pend_q, pend_jt_q, jt_flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:      if (!por_i) state_d = ST_LATCH;
            ST_IDLE:     if (por_i) state_d = ST_POR;
                         else if (any_i) state_d = ST_LATCH;
            ST_LATCH:    state_d = ST_ANNOUNCE;
            ST_ANNOUNCE: if (por_i) state_d = ST_POR;
                         else if (pend_q || any_i) state_d = ST_LATCH;
                         else state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rev_o     <= '0;
            start_o   <= '0;
            cnt_o     <= '0;
            valid_o   <= 1'b0;
            stb_o     <= 1'b0;
            go_o      <= 1'b0;
            pend_q    <= 1'b0;
            pend_jt_q <= 1'b0;
            jt_flag_q <= 1'b0;
        end else begin
            stb_o <= (state_q == ST_ANNOUNCE) && valid_o;
            go_o  <= (state_q == ST_ANNOUNCE) && jt_flag_q;
            unique case (state_q)
                ST_POR: begin
                    pend_q    <= 1'b0;
                    pend_jt_q <= 1'b0;
                    jt_flag_q <= 1'b0;
                end
                ST_IDLE: begin
                    if (any_i) jt_flag_q <= trig_i.jt_rise;
                end
                ST_LATCH: begin
                    rev_o   <= sel_i;
                    start_o <= start_i;
                    cnt_o   <= len_i;
                    valid_o <= (len_i != '0);
                    if (any_i) begin
                        pend_q    <= 1'b1;
                        pend_jt_q <= pend_jt_q | trig_i.jt_rise;
                    end
                end
                ST_ANNOUNCE: begin
                    jt_flag_q <= pend_jt_q | (any_i & trig_i.jt_rise);
                    pend_q    <= 1'b0;
                    pend_jt_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rev_select_top.sv
module rev_select_top
    import rsel_pkg::*;
#(
    parameter int BIDX_W = 4,
    parameter int BLEN_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por_i,
    input  logic                     ce_n_i,
    input  logic                     oe_rst_n_i,
    input  logic                     cfg_n_i,
    input  logic                     cfg_req_i,
    input  logic                     use_int_i,
    input  logic [1:0]               sel_pin_i,
    input  logic [1:0]               sel_int_i,
    input  logic [4*BIDX_W-1:0]      tbl_start_i,
    input  logic [4*BLEN_W-1:0]      tbl_len_i,
    output logic [1:0]               rev_o,
    output logic [BIDX_W-1:0]        start_blk_o,
    output logic [BLEN_W-1:0]        blk_cnt_o,
    output logic                     rev_valid_o,
    output logic                     sample_stb_o,
    output logic                     cfg_go_o
);
    logic [SB_W-1:0]   raw, sync;
    rsel_trig_t        trig;
    logic              any_trig, por_lvl;
    logic [SEL_W-1:0]  sel_now;
    logic [BIDX_W-1:0] start_arr [NREV];
    logic [BLEN_W-1:0] len_arr   [NREV];

    always_comb begin
        raw = '0;
        raw[SB_CE]   = ce_n_i;
        raw[SB_OE]   = oe_rst_n_i;
        raw[SB_CF]   = cfg_n_i;
        raw[SB_JT]   = cfg_req_i;
        raw[SB_POR]  = por_i;
        raw[SB_MODE] = use_int_i;
        raw[SB_PIN +: SEL_W] = sel_pin_i;
        raw[SB_INT +: SEL_W] = sel_int_i;
    end

    rsel_sync #(.W(SB_W), .RST_VAL(SB_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(sync)
    );

    rsel_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sync_i(sync),
        .trig_o(trig), .any_o(any_trig), .por_o(por_lvl)
    );

    for (genvar i = 0; i < NREV; i++) begin : g_tbl
        assign start_arr[i] = tbl_start_i[i*BIDX_W +: BIDX_W];
        assign len_arr[i]   = tbl_len_i[i*BLEN_W +: BLEN_W];
    end

    assign sel_now = sync[SB_MODE] ? sync[SB_INT +: SEL_W] : sync[SB_PIN +: SEL_W];

    rsel_fsm #(.BIDX_W(BIDX_W), .BLEN_W(BLEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .por_i(por_lvl),
        .trig_i(trig), .any_i(any_trig), .sel_i(sel_now),
        .start_i(start_arr[sel_now]), .len_i(len_arr[sel_now]),
        .rev_o(rev_o), .start_o(start_blk_o), .cnt_o(blk_cnt_o),
        .valid_o(rev_valid_o), .stb_o(sample_stb_o), .go_o(cfg_go_o)
    );
endmodule

// File: rtl/rsel_chk.sv
module rsel_chk #(
    parameter int BIDX_W = 4,
    parameter int BLEN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rev_o,
    input logic [BIDX_W-1:0] start_blk_o,
    input logic [BLEN_W-1:0] blk_cnt_o,
    input logic              rev_valid_o,
    input logic              sample_stb_o,
    input logic              cfg_go_o
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |=> !sample_stb_o); // R9
    AST_STB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (rev_valid_o && blk_cnt_o != '0)); // R8
    AST_STB_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> ($stable(rev_o) && $stable(start_blk_o))); // R9
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_go_o |=> !cfg_go_o); // R7
    AST_GO_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_go_o |-> $stable(rev_o)); // R7
endmodule

bind rev_select_top rsel_chk #(.BIDX_W(BIDX_W), .BLEN_W(BLEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rev_o(rev_o), .start_blk_o(start_blk_o),
    .blk_cnt_o(blk_cnt_o), .rev_valid_o(rev_valid_o),
    .sample_stb_o(sample_stb_o), .cfg_go_o(cfg_go_o)
);

// File: tb/rev_select_top_bench.sv
module rev_select_top_bench;
    localparam int BW = 4;
    localparam int LW = 4;

    logic clk = 1'b0, rst_n = 1'b0, por = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, cf_n = 1'b1, req = 1'b0, use_int = 1'b0;
    logic [1:0] spin = 2'd0, sint = 2'd0;
    logic [4*BW-1:0] tstart;
    logic [4*LW-1:0] tlen;
    logic [1:0] rev;
    logic [BW-1:0] sblk;
    logic [LW-1:0] cnt;
    logic valid, stb, go;

    int errors = 0, checks = 0;
    int lens [4] = '{2, 1, 0, 4};
    int starts [4];
    int stb_n, go_n, stb_at, go_at;
    logic [1:0] rev_at4;

    always #10 clk = ~clk;

    rev_select_top #(.BIDX_W(BW), .BLEN_W(LW)) u_rev_select_top (
        .clk(clk), .rst_n(rst_n), .por_i(por), .ce_n_i(ce_n), .oe_rst_n_i(oe_n),
        .cfg_n_i(cf_n), .cfg_req_i(req), .use_int_i(use_int), .sel_pin_i(spin),
        .sel_int_i(sint), .tbl_start_i(tstart), .tbl_len_i(tlen), .rev_o(rev),
        .start_blk_o(sblk), .blk_cnt_o(cnt), .rev_valid_o(valid),
        .sample_stb_o(stb), .cfg_go_o(go)
    );

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    // count negedges; record first strobe / go index and rev at index 4
    task automatic watch(input int n);
        stb_n = 0; go_n = 0; stb_at = 0; go_at = 0; rev_at4 = rev;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 4) rev_at4 = rev;
            if (stb) begin stb_n++; if (stb_at == 0) stb_at = i; end
            if (go) begin go_n++; if (go_at == 0) go_at = i; end
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_entry(input int r, input string tag);
        chk(rev == 2'(r), {tag, " R1 rev"}, rev, r);
        chk(sblk == BW'(starts[r]), "R8 R10 start", sblk, starts[r]);
        chk(cnt == LW'(lens[r]), "R8 R10 count", cnt, lens[r]);
        chk(valid == (lens[r] != 0), "R8 valid", valid, lens[r] != 0);
        chk(stb_n == ((lens[r] != 0) ? 1 : 0), "R8 R9 strobe count", stb_n, (lens[r] != 0));
    endtask

    // kind: 0 ce rise, 1 oe fall, 2 cf rise, 3 request
    task automatic fire(input int kind);
        unique case (kind)
            0: begin ce_n = 1'b0; settle(4); ce_n = 1'b1; end
            1: begin ce_n = 1'b0; oe_n = 1'b1; settle(4); oe_n = 1'b0; end
            2: begin ce_n = 1'b0; cf_n = 1'b0; settle(4); cf_n = 1'b1; end
            default: begin req = 1'b1; end
        endcase
        watch(10);
        req = 1'b0; oe_n = 1'b1;
        settle(3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int acc = 0;
        for (int i = 0; i < 4; i++) begin
            starts[i] = acc;
            acc += lens[i];
            tstart[i*BW +: BW] = BW'(starts[i]);
            tlen[i*LW +: LW] = LW'(lens[i]);
        end
        settle(3);
        chk(rev == 0 && sblk == 0 && cnt == 0 && !valid && !stb && !go, "R4 reset", rev, 0);
        rst_n = 1'b1;
        spin = 2'd3;
        watch(10);
        chk(stb_n == 0 && rev == 0, "R4 no latch under por", stb_n, 0);
        por = 1'b0;
        watch(10);
        check_entry(3, "R4 power-up");
        chk(go_n == 0, "R4 no go", go_n, 0);

        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 4; p++)
                for (int q = 0; q < 4; q++)
                    for (int k = 0; k < 4; k++) begin
                        int e;
                        use_int = m[0]; spin = 2'(p); sint = 2'(q);
                        e = m ? q : p;
                        fire(k);
                        check_entry(e, m ? "R3" : "R2");
                        if (lens[e] != 0)
                            chk(stb_at == 5, "R9 strobe timing", stb_at, 5);
                        chk(rev_at4 == 2'(e), "R9 rev at edge 4", rev_at4, e);
                        if (k == 3) begin
                            chk(go_n == 1 && go_at == 5, "R7 go pulse", go_at, 5);
                        end else begin
                            chk(go_n == 0, "R7 no go", go_n, 0);
                        end
                        if (k == 0) chk(stb_n + (lens[e] == 0) == 1, "R5 ce rise", stb_n, 1);
                        if (k == 1 || k == 2) chk(rev == 2'(e), "R6 qualified edge", rev, e);
                    end

        // establish revision 1 via pins, chip enabled
        use_int = 1'b0; spin = 2'd1;
        fire(1);
        check_entry(1, "R6 base");
        // chip disabled: oe fall and cf rise ignored
        spin = 2'd0;
        ce_n = 1'b1; settle(8);
        watch(2);
        oe_n = 1'b1; settle(4); spin = 2'd3;
        oe_n = 1'b0; watch(10);
        chk(rev == 2'd0 && stb_n == 0, "R6 oe ignored while disabled", stb_n, 0);
        oe_n = 1'b1;
        cf_n = 1'b0; settle(4); spin = 2'd1; cf_n = 1'b1; watch(10);
        chk(rev == 2'd0 && stb_n == 0, "R6 cf ignored while disabled", rev, 0);
        // ce falling edge does not latch
        spin = 2'd3;
        ce_n = 1'b0; watch(10);
        chk(rev == 2'd0 && stb_n == 0, "R5 ce fall ignored", rev, 0);
        // select changes alone ignored
        spin = 2'd1; use_int = 1'b1; sint = 2'd3; watch(10);
        chk(rev == 2'd0 && stb_n == 0, "R6 select change ignored", rev, 0);
        // por reasserted and released samples again
        por = 1'b1; watch(10);
        chk(stb_n == 0, "R4 no latch while por", stb_n, 0);
        por = 1'b0; watch(10);
        check_entry(3, "R4 re-power");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule